// File: doc/BRIEF.md
# Programmable GPIO Port Controller

This block manages one port of up to 32 I/O lines. Software writes per-line configuration through pairs of set and clear registers, so a single write changes only the bits written as 1 and never needs a read-modify-write. Each line is either a general-purpose I/O or is handed to one of four peripheral functions. On the output side, the block selects the data and enable for each pad, applies an optional open-drain behaviour and exports a pull-up enable. On the input side, it synchronises each pin, can filter it with a one-cycle glitch rejecter or a slow-tick debouncer, and raises per-line interrupts.

An interrupt fires on any change of the filtered level. Per line, it can instead fire on a chosen edge or a chosen level. The register interface is a plain single-cycle write port and a read port with one cycle of latency. It has no back-pressure: every read request is answered on the following cycle with `rd_valid`. Peripheral data and pad levels are plain per-line vectors.

Top module: `gpio_port`

## Requirements
- R1: Configuration bank k (0 output enable, 1 output data, 2 peripheral ownership, 3 function select bit 0, 4 function select bit 1, 5 open-drain, 6 pull-up, 7 filter enable, 8 debounce select, 9 interrupt mask, 10 extra-mode enable, 11 level select, 12 polarity) is set bitwise by writing 1s at address 2k and cleared bitwise by writing 1s at address 2k+1. A read of address 2k returns the bank one cycle later, with `rd_valid` high for exactly that cycle. Address 26 holds the debounce divider, 27 reads pin levels and 28 reads interrupt status.
- R2: A line not owned by a peripheral drives its output data bit on `pad_o`, and its output-enable bit on `pad_oe`.
- R3: A peripheral-owned line takes `per_o` and `per_oe` of function {select bit 1, select bit 0}.
- R4: An open-drain line never drives high. `pad_o` is 0, and `pad_oe` is asserted only when the selected output value is 0 and the selected enable is 1.
- R5: `pad_pu` equals the pull-up bank.
- R6: Reading address 27 returns each pin's level after a two-flop synchroniser, whatever filter is selected.
- R7: With the filter enabled and debounce deselected, a pin pulse lasting one clock is rejected and a pulse lasting two clocks reaches the filtered level.
- R8: With the filter and debounce both selected, the filtered level moves only when two consecutive slow ticks (one tick every divider+1 clocks) sample the same new value. A pulse shorter than divider+1 clocks is rejected. `per_i` carries the filtered levels.
- R9: With the extra mode off, any change of a line's filtered level sets its status bit, whether the line is a GPIO or peripheral-owned.
- R10: With the extra mode on and level select 0, the status bit is set on a rising edge when polarity is 1, or on a falling edge when polarity is 0.
- R11: With the extra mode on and level select 1, the status bit is set on every cycle the filtered level equals the polarity bit, so it reappears after a read while the level persists.
- R12: Reading address 28 returns the status and clears it; an event in the read cycle is kept. `irq` is high when any status bit is set together with its mask bit.
- R13: After reset all banks, the divider and the status are 0, so `pad_oe`, `pad_o`, `pad_pu` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Register address |
| wdata | input | N | Write data, one bit per line |
| rdata | output | N | Read data, valid with rd_valid |
| rd_valid | output | 1 | High the cycle after rd_en |
| pad_i | input | N | Pin levels from the pads |
| pad_o | output | N | Pad output values |
| pad_oe | output | N | Pad output enables |
| pad_pu | output | N | Pad pull-up enables |
| per_o | input | 4xN | Output values of the four peripheral functions |
| per_oe | input | 4xN | Output enables of the four peripheral functions |
| per_i | output | N | Filtered pin levels to peripherals |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench targets several corner cases, each of which a faulty design would get visibly wrong. Clear registers must leave unwritten bits alone; a design that overwrites the bank instead would lose output enables. Pulses of one clock, and pulses just shorter than a debounce window, must be rejected; a filter off by one cycle would raise spurious status. Open-drain lines that hold a 1 must release rather than drive. Level interrupts must reassert after a clear-on-read while the level holds, whereas edge modes must ignore the opposite edge. The interrupt mask must hide unmasked status from `irq`; a design that ORs the raw status would assert `irq` for a peripheral line's change.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int ADDR_W = 5;
  localparam int NCFG   = 13;
  // bank indices
  localparam int CFG_OE  = 0;
  localparam int CFG_DAT = 1;
  localparam int CFG_OWN = 2;
  localparam int CFG_FS0 = 3;
  localparam int CFG_FS1 = 4;
  localparam int CFG_OD  = 5;
  localparam int CFG_PU  = 6;
  localparam int CFG_FLT = 7;
  localparam int CFG_DEB = 8;
  localparam int CFG_IEN = 9;
  localparam int CFG_XM  = 10;
  localparam int CFG_LVL = 11;
  localparam int CFG_POL = 12;
  localparam logic [ADDR_W-1:0] ADR_DIV = ADDR_W'(2 * NCFG);
  localparam logic [ADDR_W-1:0] ADR_PIN = ADDR_W'(2 * NCFG + 1);
  localparam logic [ADDR_W-1:0] ADR_ISR = ADDR_W'(2 * NCFG + 2);
endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int N     = 32,
  parameter int DIV_W = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic                      rd_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [N-1:0]              wdata,
  input  logic [N-1:0]              pin_lvl,
  input  logic [N-1:0]              isr,
  output logic [NCFG-1:0][N-1:0]    cfg,
  output logic [DIV_W-1:0]          div,
  output logic                      isr_rd,
  output logic [N-1:0]              rdata,
  output logic                      rd_valid
);
  logic [N-1:0] rd_mux;

  for (genvar k = 0; k < NCFG; k++) begin : g_bank
    localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(2 * k);
    localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(2 * k + 1);
    logic [N-1:0] bank_q;
    always_ff @(posedge clk) begin
      if (rst)                        bank_q <= '0;
      else if (wr_en && addr == SET_A) bank_q <= bank_q | wdata;
      else if (wr_en && addr == CLR_A) bank_q <= bank_q & ~wdata;
    end
    assign cfg[k] = bank_q;
  end

  always_ff @(posedge clk) begin
    if (rst)                          div <= '0;
    else if (wr_en && addr == ADR_DIV) div <= wdata[DIV_W-1:0];
  end

  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < NCFG; k++)
      if (addr == ADDR_W'(2 * k)) rd_mux = cfg[k];
    if (addr == ADR_DIV) rd_mux = N'(div);
    if (addr == ADR_PIN) rd_mux = pin_lvl;
    if (addr == ADR_ISR) rd_mux = isr;
  end

  assign isr_rd = rd_en && (addr == ADR_ISR);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/gpio_port_infilt.sv
module gpio_port_infilt #(
  parameter int N     = 32,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     pad_i,
  input  logic [N-1:0]     flt_en,
  input  logic [N-1:0]     deb_sel,
  input  logic [DIV_W-1:0] div,
  output logic [N-1:0]     pin_lvl,
  output logic [N-1:0]     lvl_f
);
  logic [N-1:0]     s1_q, s2_q;
  logic [N-1:0]     g_prev_q, g_out_q;
  logic [N-1:0]     d_smp_q, d_out_q;
  logic [DIV_W-1:0] cnt_q;
  logic             tick;

  assign tick = (cnt_q >= div);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q     <= '0;
      s2_q     <= '0;
      g_prev_q <= '0;
      g_out_q  <= '0;
      cnt_q    <= '0;
    end else begin
      s1_q     <= pad_i;
      s2_q     <= s1_q;
      g_prev_q <= s2_q;
      cnt_q    <= tick ? '0 : cnt_q + 1'b1;
      // glitch filter: accept a value seen on two consecutive clocks
      for (int i = 0; i < N; i++)
        if (s2_q[i] == g_prev_q[i]) g_out_q[i] <= s2_q[i];
    end
  end

  // debounce: accept a value seen on two consecutive slow ticks
  always_ff @(posedge clk) begin
    if (rst) begin
      d_smp_q <= '0;
      d_out_q <= '0;
    end else if (tick) begin
      d_smp_q <= s2_q;
      for (int i = 0; i < N; i++)
        if (s2_q[i] == d_smp_q[i]) d_out_q[i] <= s2_q[i];
    end
  end

  assign pin_lvl = s2_q;
  assign lvl_f   = (flt_en & ((deb_sel & d_out_q) | (~deb_sel & g_out_q)))
                 | (~flt_en & s2_q);
endmodule

// File: rtl/gpio_port_irq.sv
module gpio_port_irq #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl_f,
  input  logic [N-1:0] xm,
  input  logic [N-1:0] lvl_sel,
  input  logic [N-1:0] pol,
  input  logic [N-1:0] ien,
  input  logic         isr_rd,
  output logic [N-1:0] isr,
  output logic         irq
);
  logic [N-1:0] prev_q, chg, rise, fall, edge_hit, lvl_hit, evt;

  assign chg      = lvl_f ^ prev_q;
  assign rise     = lvl_f & ~prev_q;
  assign fall     = ~lvl_f & prev_q;
  assign edge_hit = (pol & rise) | (~pol & fall);
  assign lvl_hit  = ~(lvl_f ^ pol);
  assign evt      = (~xm & chg) | (xm & lvl_sel & lvl_hit) | (xm & ~lvl_sel & edge_hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      isr    <= '0;
    end else begin
      prev_q <= lvl_f;
      isr    <= isr_rd ? evt : (isr | evt);
    end
  end

  assign irq = |(isr & ien);
endmodule

// File: rtl/gpio_port_omux.sv
module gpio_port_omux #(
  parameter int N = 32
) (
  input  logic [N-1:0]        oe,
  input  logic [N-1:0]        dat,
  input  logic [N-1:0]        own,
  input  logic [N-1:0]        fs0,
  input  logic [N-1:0]        fs1,
  input  logic [N-1:0]        od,
  input  logic [N-1:0]        pu,
  input  logic [3:0][N-1:0]   per_o,
  input  logic [3:0][N-1:0]   per_oe,
  output logic [N-1:0]        pad_o,
  output logic [N-1:0]        pad_oe,
  output logic [N-1:0]        pad_pu
);
  for (genvar i = 0; i < N; i++) begin : g_line
    logic [1:0] sel;
    logic       v, e;
    assign sel       = {fs1[i], fs0[i]};
    assign v         = own[i] ? per_o[sel][i]  : dat[i];
    assign e         = own[i] ? per_oe[sel][i] : oe[i];
    assign pad_o[i]  = v & ~od[i];
    assign pad_oe[i] = e & (~od[i] | ~v);
  end
  assign pad_pu = pu;
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int N     = 32,
  parameter int DIV_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [N-1:0]          wdata,
  output logic [N-1:0]          rdata,
  output logic                  rd_valid,
  input  logic [N-1:0]          pad_i,
  output logic [N-1:0]          pad_o,
  output logic [N-1:0]          pad_oe,
  output logic [N-1:0]          pad_pu,
  input  logic [3:0][N-1:0]     per_o,
  input  logic [3:0][N-1:0]     per_oe,
  output logic [N-1:0]          per_i,
  output logic                  irq
);
  logic [NCFG-1:0][N-1:0] cfg;
  logic [DIV_W-1:0]       div;
  logic [N-1:0]           pin_lvl, lvl_f, isr, cfg_od, cfg_ien;
  logic                   isr_rd;

  assign cfg_od  = cfg[CFG_OD];
  assign cfg_ien = cfg[CFG_IEN];

  gpio_port_regs #(.N(N), .DIV_W(DIV_W)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .pin_lvl(pin_lvl), .isr(isr), .cfg(cfg), .div(div),
    .isr_rd(isr_rd), .rdata(rdata), .rd_valid(rd_valid)
  );

  gpio_port_infilt #(.N(N), .DIV_W(DIV_W)) filt_i (
    .clk(clk), .rst(rst), .pad_i(pad_i), .flt_en(cfg[CFG_FLT]),
    .deb_sel(cfg[CFG_DEB]), .div(div), .pin_lvl(pin_lvl), .lvl_f(lvl_f)
  );

  gpio_port_irq #(.N(N)) irq_i (
    .clk(clk), .rst(rst), .lvl_f(lvl_f), .xm(cfg[CFG_XM]),
    .lvl_sel(cfg[CFG_LVL]), .pol(cfg[CFG_POL]), .ien(cfg_ien),
    .isr_rd(isr_rd), .isr(isr), .irq(irq)
  );

  gpio_port_omux #(.N(N)) omux_i (
    .oe(cfg[CFG_OE]), .dat(cfg[CFG_DAT]), .own(cfg[CFG_OWN]),
    .fs0(cfg[CFG_FS0]), .fs1(cfg[CFG_FS1]), .od(cfg_od), .pu(cfg[CFG_PU]),
    .per_o(per_o), .per_oe(per_oe), .pad_o(pad_o), .pad_oe(pad_oe),
    .pad_pu(pad_pu)
  );

  assign per_i = lvl_f;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int N = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         rd_en,
  input logic         rd_valid,
  input logic [N-1:0] pad_o,
  input logic [N-1:0] pad_oe,
  input logic [N-1:0] od,
  input logic [N-1:0] ien,
  input logic         irq
);
  // R1: a read answer appears only the cycle after a request
  a_r1_rvalid_follows: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_en));

  // R4: an open-drain line that is driven is driven low
  a_r4_od_low_only: assert property (@(posedge clk) disable iff (rst)
    ((pad_oe & pad_o & od) == '0));

  // R12: no request without some mask bit set
  a_r12_irq_needs_mask: assert property (@(posedge clk) disable iff (rst)
    irq |-> (|ien));

  // R13: reset leaves every pad undriven and the request low
  a_r13_reset_quiet: assert property (@(posedge clk)
    rst |=> ((pad_oe == '0) && !irq));
endmodule

bind gpio_port gpio_port_chk #(.N(N)) chk_i (
  .clk(clk), .rst(rst), .rd_en(rd_en), .rd_valid(rd_valid),
  .pad_o(pad_o), .pad_oe(pad_oe), .od(cfg_od), .ien(cfg_ien), .irq(irq)
);

// File: tb/gpio_port_tb_top.sv
module gpio_port_tb_top;
  localparam int CLK_NS = 10;

  // register map (R1)
  localparam logic [4:0] OE_S = 5'd0,  OE_C = 5'd1,  DAT_S = 5'd2, DAT_C = 5'd3;
  localparam logic [4:0] OWN_S = 5'd4, FS0_S = 5'd6, FS1_S = 5'd8;
  localparam logic [4:0] OD_S = 5'd10, PU_S = 5'd12, FLT_S = 5'd14, DEB_S = 5'd16;
  localparam logic [4:0] IEN_S = 5'd18, XM_S = 5'd20, LVL_S = 5'd22;
  localparam logic [4:0] POL_S = 5'd24, POL_C = 5'd25;
  localparam logic [4:0] DIV_A = 5'd26, PIN_A = 5'd27, ISR_A = 5'd28;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0]        addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata, pad_o, pad_oe, pad_pu, per_i;
  logic              rd_valid, irq;
  logic [31:0]       pad_i = '0;
  logic [3:0][31:0]  per_o = '0, per_oe = '0;

  int checks = 0, failures = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          done = 1'b0;

  always #(CLK_NS / 2) clk = ~clk;

  gpio_port dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .pad_i(pad_i),
    .pad_o(pad_o), .pad_oe(pad_oe), .pad_pu(pad_pu), .per_o(per_o),
    .per_oe(per_oe), .per_i(per_i), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // driver side of the scoreboard
  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); rd_en = 1'b1; addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); rd_en = 1'b0;
  endtask

  // monitor side of the scoreboard
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) chk("R1 unexpected read answer", rdata, 32'hx);
      else chk(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  initial begin
    #(CLK_NS * 100000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    // R13 reset state
    chk("R13 pad_oe", pad_oe, 32'h0);
    chk("R13 pad_o", pad_o, 32'h0);
    chk("R13 pad_pu", pad_pu, 32'h0);
    chk("R13 irq", {31'h0, irq}, 32'h0);
    rd(ISR_A, 32'h0, "R13 status");

    // R1 set/clear banks
    wr(OE_S, 32'hFF);
    wr(DAT_S, 32'hF0);
    wr(DAT_C, 32'h10);
    rd(DAT_S, 32'hE0, "R1 data bank after clear");
    wr(OE_C, 32'h80);
    rd(OE_S, 32'h7F, "R1 enable bank after clear");

    // R2 GPIO drive
    chk("R2 pad_o", pad_o, 32'hE0);
    chk("R2 pad_oe", pad_oe, 32'h7F);

    // R3 peripheral mux, line 8
    per_o[2] = '1; per_oe[2] = '1;
    wr(OWN_S, 32'h100);
    wr(FS1_S, 32'h100);
    chk("R3 function 2 value", {31'h0, pad_o[8]}, 32'h1);
    chk("R3 function 2 enable", {31'h0, pad_oe[8]}, 32'h1);
    wr(FS0_S, 32'h100);
    chk("R3 function 3 value", {31'h0, pad_o[8]}, 32'h0);
    chk("R3 function 3 enable", {31'h0, pad_oe[8]}, 32'h0);

    // R4 open drain on lines 5,6
    wr(OD_S, 32'h60);
    chk("R4 released enable", {24'h0, pad_oe[7:0]}, 32'h1F);
    chk("R4 values", {24'h0, pad_o[7:0]}, 32'h80);
    wr(DAT_C, 32'h20);
    chk("R4 driven low", {24'h0, pad_oe[7:0]}, 32'h3F);

    // R5 pull-up
    wr(PU_S, 32'h3);
    chk("R5 pad_pu", pad_pu, 32'h3);

    // R6 pin status and R9 change status
    pad_i = 32'hA5A5_0001;
    idle(6);
    rd(PIN_A, 32'hA5A5_0001, "R6 pin levels");
    rd(ISR_A, 32'hA5A5_0001, "R9 change status");
    rd(ISR_A, 32'h0, "R12 cleared on read");
    chk("R12 irq unmasked", {31'h0, irq}, 32'h0);
    wr(IEN_S, 32'h1);
    pad_i[0] = 1'b0;
    idle(6);
    chk("R12 irq masked-in", {31'h0, irq}, 32'h1);
    rd(ISR_A, 32'h1, "R12 status line 0");
    chk("R12 irq after read", {31'h0, irq}, 32'h0);
    pad_i[8] = 1'b1;
    idle(6);
    chk("R12 irq ignores unmasked line", {31'h0, irq}, 32'h0);
    rd(ISR_A, 32'h100, "R9 peripheral line change");

    // R7 glitch filter on line 1
    wr(FLT_S, 32'h2);
    pad_i[1] = 1'b1; @(negedge clk); pad_i[1] = 1'b0;
    idle(8);
    rd(ISR_A, 32'h0, "R7 one-clock pulse rejected");
    pad_i[1] = 1'b1; idle(2); pad_i[1] = 1'b0;
    idle(8);
    rd(ISR_A, 32'h2, "R7 two-clock pulse passed");

    // R8 debounce on line 2, divider 3
    wr(DIV_A, 32'd3);
    rd(DIV_A, 32'd3, "R1 divider readback");
    wr(FLT_S, 32'h4);
    wr(DEB_S, 32'h4);
    pad_i[2] = 1'b1; idle(3); pad_i[2] = 1'b0;
    idle(20);
    rd(ISR_A, 32'h0, "R8 short pulse rejected");
    chk("R8 per_i low", {31'h0, per_i[2]}, 32'h0);
    pad_i[2] = 1'b1;
    idle(20);
    chk("R8 per_i high", {31'h0, per_i[2]}, 32'h1);
    rd(ISR_A, 32'h4, "R8 stable level passed");

    // R10 edge modes on line 3
    wr(POL_S, 32'h8);
    wr(XM_S, 32'h8);
    pad_i[3] = 1'b1; idle(6);
    rd(ISR_A, 32'h8, "R10 rising edge");
    pad_i[3] = 1'b0; idle(6);
    rd(ISR_A, 32'h0, "R10 falling ignored in rising mode");
    wr(POL_C, 32'h8);
    pad_i[3] = 1'b1; idle(6);
    rd(ISR_A, 32'h0, "R10 rising ignored in falling mode");
    pad_i[3] = 1'b0; idle(6);
    rd(ISR_A, 32'h8, "R10 falling edge");

    // R11 level modes on line 4
    wr(POL_S, 32'h10);
    wr(LVL_S, 32'h10);
    wr(XM_S, 32'h10);
    rd(ISR_A, 32'h0, "R11 no status while low in high mode");
    pad_i[4] = 1'b1; idle(6);
    rd(ISR_A, 32'h10, "R11 high level");
    rd(ISR_A, 32'h10, "R11 reasserts while high");
    pad_i[4] = 1'b0; idle(6);
    rd(ISR_A, 32'h10, "R11 held until read");
    rd(ISR_A, 32'h0, "R11 gone after level drops");

    idle(4);
    chk("R1 scoreboard drained", exp_q.size(), 32'h0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule